// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller

This block is a clocked model of the control logic that sits in front of a byte-alterable nonvolatile memory array. The host drives active-low chip-enable, write-enable and output-enable strobes together with an address and a data byte, and the block samples them on every clock. Reads return array contents. Writes are gathered into a page buffer, either as one byte or as a run of bytes that share one page. When the host stops loading bytes for longer than a programmable window, the block starts a self-timed programming cycle. At the end of that cycle the buffered bytes are copied into the array.

While programming runs, a read does not return array data. It returns a status byte instead. The top bit of that byte is the inverse of bit 7 of the last byte loaded, and bit 6 flips after every completed read access. Host software can therefore poll for completion with one of two methods: compare bit 7 against the last byte written, or look for bit 6 to stop changing between reads. The array width and page size are parameters. The full-size build uses a 15-bit address, and the default here is kept smaller so that elaboration stays light.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write cycle is recognised only in a sampled cycle where ceN and weN are both 0 and oeN is 1. Holding all three low loads nothing and starts no programming.
- R2: The address is latched in the first sampled cycle in which both ceN and weN are low. The data byte is the one present in the last sampled cycle in which both were low. Address or data changes outside those cycles have no effect.
- R3: A page holds 2**PAGE_BITS bytes, and address bits [ADDR_W-1:PAGE_BITS] select the page. The first byte fixes the open page. A later byte from another page is dropped and does not restart the load timer.
- R4: Programming begins LOAD_TIMEOUT clock cycles after the start of the last accepted byte load. It does not begin while a write is still in progress. A read before that point returns array data.
- R5: Programming lasts exactly PROG_CYCLES cycles. The buffered bytes then appear in the array, and if an offset was loaded more than once, the later byte wins. Bytes at offsets that were never loaded keep their old values.
- R6: While programming runs, a read returns the complement of the last loaded byte's bit 7 on dataOut[7], and that byte's bits 5:0 on dataOut[5:0].
- R7: While programming runs, dataOut[6] takes the opposite value on each successive read access. It flips when a read access ends.
- R8: dataOe is 1 only when ceN and oeN are both 0.
- R9: Write cycles that start while programming runs are ignored.
- R10: After reset the array reads all zeros, no page is open and no programming is in progress.
- R11: Outside programming, including while a page is being loaded, a read returns the array contents at the given address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data from the host |
| dataOut | output | DATA_W | Read data or status byte |
| dataOe | output | 1 | Output drive enable; when 0 the bus is treated as high impedance |

## Verification
The assertions check four properties on every cycle: that the bus is not driven unless both enables are low, that polled bit 7 stays inverted for the whole programming phase, that the last loaded byte stays frozen while programming runs, and that the programming phase lasts exactly PROG_CYCLES cycles. The bench scenarios are needed for everything that depends on the order of events. That covers the address and data capture edges, dropping bytes from a foreign page, a repeated offset where the later byte wins, the load timeout firing, bit 6 flipping between reads, and writes being ignored during programming. These can only be seen by reading the array back after a commit.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } engState_t;

  typedef struct packed {
    logic holdData;
    logic captureAddr;
    logic openPage;
    logic storeByte;
    logic commitPage;
    logic flipToggle;
    logic busy;
  } ctrlStrobes_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 12500,
  parameter int PROG_CYCLES  = 375000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         weN,
  input  logic         oeN,
  input  logic         pageMatch,
  output ctrlStrobes_t strobes
);
  localparam int LW = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [LW-1:0] LOAD_LAST = LW'(LOAD_TIMEOUT - 1);
  localparam logic [LW-1:0] LOAD_MAX  = LW'(LOAD_TIMEOUT);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 1);

  engState_t   state;
  logic [LW-1:0] loadCnt;
  logic [PW-1:0] progCnt;
  logic writePrev, readPrev, pending;

  logic writeActive, readActive, writeStart, writeEnd, readEnd, accept;
  logic expire, commit;

  assign writeActive = !ceN && !weN && oeN;
  assign readActive  = !ceN && !oeN;
  assign writeStart  = writeActive && !writePrev;
  assign writeEnd    = !writeActive && writePrev;
  assign readEnd     = !readActive && readPrev;
  assign accept      = writeStart &&
                       ((state == ST_IDLE) || ((state == ST_LOAD) && pageMatch));
  assign expire      = (state == ST_LOAD) && !accept && (loadCnt >= LOAD_LAST) &&
                       !writeActive && !pending;
  assign commit      = (state == ST_PROG) && (progCnt == PROG_LAST);

  always_comb begin
    strobes             = '0;
    strobes.holdData    = writeActive;
    strobes.captureAddr = accept;
    strobes.openPage    = accept && (state == ST_IDLE);
    strobes.storeByte   = writeEnd && pending;
    strobes.commitPage  = commit;
    strobes.flipToggle  = readEnd && (state == ST_PROG);
    strobes.busy        = (state == ST_PROG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      loadCnt   <= '0;
      progCnt   <= '0;
      writePrev <= 1'b0;
      readPrev  <= 1'b0;
      pending   <= 1'b0;
    end else begin
      writePrev <= writeActive;
      readPrev  <= readActive;
      if (accept)        pending <= 1'b1;
      else if (writeEnd) pending <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_LOAD;
            loadCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            loadCnt <= '0;
          end else if (expire) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else if (loadCnt != LOAD_MAX) begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (commit) state <= ST_IDLE;
          else        progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobes_t      strobes,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] lastData
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int PAGE_W    = ADDR_W - PAGE_BITS;

  logic [DATA_W-1:0]    mem     [DEPTH];
  logic [DATA_W-1:0]    pageBuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] valid;
  logic [PAGE_W-1:0]    openPageReg;
  logic [PAGE_BITS-1:0] offsetLatch;
  logic [DATA_W-1:0]    dataHold;
  logic                 toggleBit;

  assign pageMatch = (addr[ADDR_W-1:PAGE_BITS] == openPageReg);

  always_ff @(posedge clk) begin
    if (strobes.holdData) dataHold <= dataIn;
    if (strobes.storeByte) pageBuf[offsetLatch] <= dataHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid       <= '0;
      openPageReg <= '0;
      offsetLatch <= '0;
      lastData    <= '0;
      toggleBit   <= 1'b0;
    end else begin
      if (strobes.openPage)    openPageReg <= addr[ADDR_W-1:PAGE_BITS];
      if (strobes.captureAddr) offsetLatch <= addr[PAGE_BITS-1:0];
      if (strobes.storeByte) begin
        valid[offsetLatch] <= 1'b1;
        lastData           <= dataHold;
      end
      if (strobes.commitPage) valid <= '0;
      if (strobes.flipToggle) toggleBit <= ~toggleBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.commitPage) begin
      for (int i = 0; i < PAGE_SIZE; i++)
        if (valid[i]) mem[{openPageReg, PAGE_BITS'(i)}] <= pageBuf[i];
    end
  end

  always_comb begin
    if (strobes.busy)
      dataOut = {~lastData[DATA_W-1], toggleBit, lastData[DATA_W-3:0]};
    else
      dataOut = mem[addr];
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 7,
  parameter int LOAD_TIMEOUT = 12500,
  parameter int PROG_CYCLES  = 375000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  ctrlStrobes_t      strobes;
  logic              pageMatch;
  logic              busy;
  logic [DATA_W-1:0] lastData;

  assign dataOe = !ceN && !oeN;
  assign busy   = strobes.busy;

  eeprom_ctrl #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .oeN      (oeN),
    .pageMatch(pageMatch),
    .strobes  (strobes)
  );

  eeprom_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .dataIn   (dataIn),
    .strobes  (strobes),
    .pageMatch(pageMatch),
    .dataOut  (dataOut),
    .lastData (lastData)
  );
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 375000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic              busy,
  input logic [DATA_W-1:0] lastData
);
  logic [31:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  p_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> !dataOe);

  p_poll_inverted_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataOe) |-> (dataOut[DATA_W-1] != lastData[DATA_W-1]));

  p_frozen_during_prog_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lastData));

  p_prog_length_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 32'(PROG_CYCLES)));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .DATA_W     (DATA_W),
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ceN     (ceN),
  .oeN     (oeN),
  .dataOe  (dataOe),
  .dataOut (dataOut),
  .busy    (busy),
  .lastData(lastData)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int AW = 11;
  localparam int TO = 20;
  localparam int PC = 50;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataOe;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(AW), .DATA_W(8), .PAGE_BITS(7),
    .LOAD_TIMEOUT(TO), .PROG_CYCLES(PC)
  ) u_eeprom_page_writer (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic [7:0]    e;
  } vec_t;

  // Page 3 (base 0x180); entry 3 is foreign (R3); offset 5 loaded twice (R5)
  localparam vec_t VECS [6] = '{
    '{a: 11'h180, d: 8'h11, e: 8'h11},
    '{a: 11'h185, d: 8'h22, e: 8'h5C},
    '{a: 11'h1FF, d: 8'h33, e: 8'h33},
    '{a: 11'h200, d: 8'hAA, e: 8'h00},
    '{a: 11'h1C0, d: 8'h9E, e: 8'h9E},
    '{a: 11'h185, d: 8'h5C, e: 8'h5C}
  };

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ceN = 0; weN = 0; oeN = 1; addr = a; dataIn = d;
    @(negedge clk);
    @(negedge clk); weN = 1; ceN = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); ceN = 0; oeN = 0; weN = 1; addr = a;
    #1; d = dataOut; oe = dataOe;
    @(negedge clk); ceN = 1; oeN = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic       oe;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R10 reset state, R8 drive enable
    #1; chk("R8 idle oe", {7'b0, dataOe}, 8'h00);
    rd(11'h000, d, oe); chk("R10 reset array", d, 8'h00);
    chk("R8 read oe", {7'b0, oe}, 8'h01);
    @(negedge clk); ceN = 1; oeN = 0; #1 chk("R8 ce high", {7'b0, dataOe}, 8'h00);
    @(negedge clk); ceN = 0; oeN = 1; #1 chk("R8 oe high", {7'b0, dataOe}, 8'h00);
    @(negedge clk); ceN = 1;

    // Table walk: page load, then timeout, poll, commit, readback
    for (int i = 0; i < 6; i++) wr(VECS[i].a, VECS[i].d);
    rd(11'h180, d, oe); chk("R4 R11 before timeout", d, 8'h00);
    idle(TO + 5);
    rd(11'h180, d, oe); chk("R6 status", d & 8'hBF, 8'h9C);
    rd(11'h185, d2, oe); chk("R7 toggle", d2[6] ? 8'h01 : 8'h00, d[6] ? 8'h00 : 8'h01);
    wr(11'h7F0, 8'h66);      // R9 write during programming
    idle(PC);
    for (int i = 0; i < 6; i++) begin
      rd(VECS[i].a, d, oe);
      chk("R3 R5 readback", d, VECS[i].e);
    end
    rd(11'h181, d, oe); chk("R5 unloaded offset", d, 8'h00);
    rd(11'h7F0, d, oe); chk("R9 ignored", d, 8'h00);

    // R1: all three low is not a write
    @(negedge clk); ceN = 0; weN = 0; oeN = 0; addr = 11'h010; dataIn = 8'h77;
    idle(3);
    @(negedge clk); ceN = 1; weN = 1; oeN = 1;
    idle(TO + PC + 10);
    rd(11'h010, d, oe); chk("R1 no write", d, 8'h00);

    // R2: address at later falling, data at first rising
    @(negedge clk); ceN = 0; addr = 11'h300; dataIn = 8'h01;
    @(negedge clk); weN = 0; addr = 11'h301; dataIn = 8'h02;
    @(negedge clk); addr = 11'h302; dataIn = 8'h44;
    @(negedge clk); weN = 1; dataIn = 8'h99;
    @(negedge clk); ceN = 1;
    idle(TO + PC + 10);
    rd(11'h301, d, oe); chk("R2 captured byte", d, 8'h44);
    rd(11'h300, d, oe); chk("R2 early address", d, 8'h00);
    rd(11'h302, d, oe); chk("R2 late address", d, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule